// File: doc/BRIEF.md
# Error-Correction Engine Register Front End

This block is the software-facing register shell that sits in front of a BCH error-correction engine. Software programs a block length, a parity length and a mode, then streams the payload (and, when decoding, the stored parity) through a single data port using full-word writes and single-byte writes for any trailing bytes. The shell counts the bytes that arrive. Once the programmed total is in, it waits a fixed processing latency and then raises an encode-finished or decode-finished status flag.

The arithmetic of the code itself is not part of this block. The engine that does it writes parity words, error-report entries and the decode verdict (errors found, uncorrectable, total errors, number of report entries) through a side port. Software reads these results back through windows in the register map. Status flags are cleared by writing 1 to them, so software can acknowledge everything it has just read by writing back the same value. An interrupt line is raised while any pending status flag has its enable bit set.

Top module: `ecc_regfront`

## Requirements
- R1: After reset every readable register reads 0 and `irq` is low.
- R2: A write to byte offset 0x00 loads the control register through the byte lanes that are enabled. The control register holds run-enable at bit 0, init at bit 1, encode-select at bit 2 and a 7-bit strength field at bits 10:4, and all other bits read 0. A write to offset 0x0C clears every control bit that is written as 1.
- R3: The init bit reads 1 for exactly one cycle after it is written. In the following cycle the byte counter, every parity word and every error-report entry are cleared to 0.
- R4: Offset 0x04 holds an 11-bit block length in bits 10:0 and a 7-bit parity length in bits 22:16. It loads through the enabled byte lanes, and all other bits read 0.
- R5: A write to the data port at offset 0x08 adds the number of enabled byte lanes to the byte counter: 4 for `bus_be`=4'hF and 1 for any single lane. Data writes are ignored while run-enable is 0, while init is pending, and after the target has been reached until the next init.
- R6: With encode-select at 1, status bit 2 (encode finished) is set exactly DONE_DLY cycles after the clock edge that takes the counter to the block length or beyond.
- R7: With encode-select at 0, the target is block length plus parity length, and status bit 3 (decode finished) is set with the same latency.
- R8: The status register at offset 0x184 clears each of its bits 3:0 that is written as 1. Acknowledging bit 0 also clears both count fields. A flag that hardware sets in the same cycle stays set.
- R9: A side-port result load ORs in bit 0 (errors found) and bit 1 (uncorrectable), and loads the total-error count into bits 22:16 and the report-entry count into bits 30:24.
- R10: Parity word i, written through the side port, reads at 0x14+4*i. Error-report entry j reads at 0x84+4*j. Bus writes to these windows are ignored.
- R11: A write to 0x188 sets, and a write to 0x18C clears, bits of a 4-bit interrupt enable that reads back at 0x190. `irq` is high when any of status bits 3:0 is set together with its enable bit.
- R12: Unaligned addresses and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_be | input | 4 | Byte-lane enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| par_we | input | 1 | Side port: parity word write strobe |
| par_idx | input | PIDX_W | Side port: parity word index |
| par_wdata | input | 32 | Side port: parity word value |
| erep_we | input | 1 | Side port: error-report entry write strobe |
| erep_idx | input | EIDX_W | Side port: error-report entry index |
| erep_wdata | input | 32 | Side port: error-report entry value |
| res_ld | input | 1 | Side port: decode verdict load strobe |
| res_err | input | 1 | Verdict: errors were found |
| res_uncor | input | 1 | Verdict: errors are uncorrectable |
| res_total | input | 7 | Verdict: total error count |
| res_entries | input | 7 | Verdict: number of valid report entries |
| irq | output | 1 | Interrupt request |

## Verification
The byte counter is driven with all-word streams, with streams that end in single-byte writes on assorted lanes, and with random word/byte mixes whose lengths are random in both modes. Together these separate a correct per-lane count from a count that treats every write as a word or as a byte. Completion is sampled one cycle before and exactly at the expected latency, which catches off-by-one errors in the delay and in the encode/decode target. A stream pushed while the engine is disabled, followed by an enabled stream, shows whether ignored writes leak into the count. Status acknowledgements that target one bit at a time separate true per-bit clearing from whole-register clearing and from field clearing tied to the wrong bit.

// File: rtl/ecc_regfront_pkg.sv
`timescale 1ns/1ps
package ecc_regfront_pkg;

  // Byte offsets of the register map
  localparam int unsigned OFS_CTRL = 32'h000;
  localparam int unsigned OFS_CNT  = 32'h004;
  localparam int unsigned OFS_DATA = 32'h008;
  localparam int unsigned OFS_CCLR = 32'h00C;
  localparam int unsigned OFS_PAR  = 32'h014;
  localparam int unsigned OFS_EREP = 32'h084;
  localparam int unsigned OFS_STAT = 32'h184;
  localparam int unsigned OFS_IES  = 32'h188;
  localparam int unsigned OFS_IEC  = 32'h18C;
  localparam int unsigned OFS_IEV  = 32'h190;

  // Control bit positions
  localparam int CB_EN   = 0;
  localparam int CB_INIT = 1;
  localparam int CB_ENC  = 2;

  // Status bit positions
  localparam int SB_ERR  = 0;
  localparam int SB_UNC  = 1;
  localparam int SB_ENCF = 2;
  localparam int SB_DECF = 3;

  localparam logic [31:0] CTRL_KEEP = 32'h0000_07F7;
  localparam logic [31:0] CNT_KEEP  = 32'h007F_07FF;

  typedef struct packed {
    logic       err;
    logic       uncor;
    logic [6:0] total;
    logic [6:0] entries;
  } ecc_res_t;

  function automatic logic [31:0] lane_mask(input logic [3:0] be);
    logic [31:0] m;
    for (int i = 0; i < 4; i++) m[8*i +: 8] = {8{be[i]}};
    return m;
  endfunction

endpackage

// File: rtl/ecc_feed_counter.sv
`timescale 1ns/1ps
module ecc_feed_counter #(
  parameter int DONE_DLY = 4,
  parameter int BLK_W    = 11,
  parameter int PAR_W    = 7,
  localparam int CNT_W   = BLK_W + 1,
  localparam int TMR_W   = $clog2(DONE_DLY + 1)
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             init_i,
  input  logic             enc_i,
  input  logic             push_i,
  input  logic [2:0]       lanes_i,
  input  logic [BLK_W-1:0] blk_i,
  input  logic [PAR_W-1:0] par_i,
  output logic             enc_done_o,
  output logic             dec_done_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d, sum, tgt;
  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic             hit_q, hit_d, busy_q, busy_d, encm_q, encm_d;
  logic             acc, reach, fire, st_ce;

  always_comb begin
    tgt   = enc_i ? CNT_W'(blk_i) : CNT_W'(blk_i) + CNT_W'(par_i);
    acc   = push_i && !hit_q;
    sum   = cnt_q + CNT_W'(lanes_i);
    reach = acc && (sum >= tgt);
    fire  = busy_q && (tmr_q == TMR_W'(1)) && !init_i;
    st_ce = init_i | acc | busy_q;

    cnt_d  = cnt_q;
    hit_d  = hit_q;
    busy_d = busy_q;
    tmr_d  = tmr_q;
    encm_d = encm_q;
    if (init_i) begin
      cnt_d  = '0;
      hit_d  = 1'b0;
      busy_d = 1'b0;
      tmr_d  = '0;
    end else begin
      if (acc) cnt_d = sum;
      if (reach) begin
        hit_d  = 1'b1;
        busy_d = 1'b1;
        tmr_d  = TMR_W'(DONE_DLY);
        encm_d = enc_i;
      end else if (busy_q) begin
        tmr_d = tmr_q - TMR_W'(1);
        if (tmr_q == TMR_W'(1)) busy_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      hit_q  <= 1'b0;
      busy_q <= 1'b0;
      tmr_q  <= '0;
      encm_q <= 1'b0;
    end else if (st_ce) begin
      cnt_q  <= cnt_d;
      hit_q  <= hit_d;
      busy_q <= busy_d;
      tmr_q  <= tmr_d;
      encm_q <= encm_d;
    end
  end

  assign enc_done_o = fire && encm_q;
  assign dec_done_o = fire && !encm_q;

  // R5
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (hit_q && !init_i) |=> (cnt_q == $past(cnt_q)));

  // R3
  cnt_init_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    init_i |=> (cnt_q == '0 && !hit_q && !busy_q));

  // R6
  done_after_hit_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (enc_done_o || dec_done_o) |-> hit_q);

endmodule

// File: rtl/ecc_result_store.sv
`timescale 1ns/1ps
module ecc_result_store #(
  parameter int PAR_WORDS  = 28,
  parameter int EREP_WORDS = 64,
  parameter int PIDX_W     = 5,
  parameter int EIDX_W     = 6
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              init_i,
  input  logic              par_we_i,
  input  logic [PIDX_W-1:0] par_widx_i,
  input  logic [31:0]       par_wdata_i,
  input  logic [PIDX_W-1:0] par_ridx_i,
  output logic [31:0]       par_rdata_o,
  input  logic              erep_we_i,
  input  logic [EIDX_W-1:0] erep_widx_i,
  input  logic [31:0]       erep_wdata_i,
  input  logic [EIDX_W-1:0] erep_ridx_i,
  output logic [31:0]       erep_rdata_o
);

  localparam logic [PIDX_W:0] PAR_LIM  = (PIDX_W+1)'(PAR_WORDS);
  localparam logic [EIDX_W:0] EREP_LIM = (EIDX_W+1)'(EREP_WORDS);

  logic [31:0] par_q  [PAR_WORDS];
  logic [31:0] erep_q [EREP_WORDS];

  for (genvar g = 0; g < PAR_WORDS; g++) begin : g_par
    logic        ce;
    logic [31:0] d;
    always_comb begin
      ce = init_i || (par_we_i && par_widx_i == PIDX_W'(g));
      d  = init_i ? 32'h0 : par_wdata_i;
    end
    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni)  par_q[g] <= '0;
      else if (ce)  par_q[g] <= d;
    end
  end

  for (genvar g = 0; g < EREP_WORDS; g++) begin : g_erep
    logic        ce;
    logic [31:0] d;
    always_comb begin
      ce = init_i || (erep_we_i && erep_widx_i == EIDX_W'(g));
      d  = init_i ? 32'h0 : erep_wdata_i;
    end
    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni)  erep_q[g] <= '0;
      else if (ce)  erep_q[g] <= d;
    end
  end

  always_comb begin
    par_rdata_o  = ({1'b0, par_ridx_i}  < PAR_LIM)  ? par_q[par_ridx_i]   : 32'h0;
    erep_rdata_o = ({1'b0, erep_ridx_i} < EREP_LIM) ? erep_q[erep_ridx_i] : 32'h0;
  end

  // R3
  store_init_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    init_i |=> (par_q[0] == 32'h0 && erep_q[0] == 32'h0));

  // R10
  par_load_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (par_we_i && !init_i && par_widx_i == '0) |=> (par_q[0] == $past(par_wdata_i)));

endmodule

// File: rtl/ecc_irq_ctrl.sv
`timescale 1ns/1ps
module ecc_irq_ctrl
  import ecc_regfront_pkg::*;
(
  input  logic        clk,
  input  logic        rst_ni,
  input  logic        stat_wr_i,
  input  logic        ies_wr_i,
  input  logic        iec_wr_i,
  input  logic [3:0]  wbits_i,
  input  logic        enc_done_i,
  input  logic        dec_done_i,
  input  logic        res_ld_i,
  input  ecc_res_t    res_i,
  output logic [31:0] stat_o,
  output logic [3:0]  ie_o,
  output logic        irq_o
);

  logic [3:0] flags_q, flags_d, ie_q, ie_d;
  logic [6:0] tot_q, tot_d, ent_q, ent_d;
  logic       flags_ce, fld_ce, ie_ce;

  always_comb begin
    flags_d = flags_q;
    if (stat_wr_i) flags_d = flags_d & ~wbits_i;
    if (enc_done_i) flags_d[SB_ENCF] = 1'b1;
    if (dec_done_i) flags_d[SB_DECF] = 1'b1;
    if (res_ld_i) begin
      if (res_i.err)   flags_d[SB_ERR] = 1'b1;
      if (res_i.uncor) flags_d[SB_UNC] = 1'b1;
    end
    flags_ce = stat_wr_i | enc_done_i | dec_done_i | res_ld_i;

    tot_d = tot_q;
    ent_d = ent_q;
    if (stat_wr_i && wbits_i[SB_ERR]) begin
      tot_d = '0;
      ent_d = '0;
    end
    if (res_ld_i) begin
      tot_d = res_i.total;
      ent_d = res_i.entries;
    end
    fld_ce = stat_wr_i | res_ld_i;

    ie_d = ie_q;
    if (ies_wr_i) ie_d = ie_d | wbits_i;
    if (iec_wr_i) ie_d = ie_d & ~wbits_i;
    ie_ce = ies_wr_i | iec_wr_i;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      tot_q   <= '0;
      ent_q   <= '0;
      ie_q    <= '0;
    end else begin
      if (flags_ce) flags_q <= flags_d;
      if (fld_ce) begin
        tot_q <= tot_d;
        ent_q <= ent_d;
      end
      if (ie_ce) ie_q <= ie_d;
    end
  end

  assign stat_o = {1'b0, ent_q, 1'b0, tot_q, 12'h000, flags_q};
  assign ie_o   = ie_q;
  assign irq_o  = |(flags_q & ie_q);

  // R8
  encf_w1c_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (stat_wr_i && wbits_i[SB_ENCF] && !enc_done_i) |=> !stat_o[SB_ENCF]);

  // R8
  encf_hw_wins_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    enc_done_i |=> stat_o[SB_ENCF]);

  // R9
  total_load_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    res_ld_i |=> (stat_o[22:16] == $past(res_i.total)));

  // R11
  ie_set_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (ies_wr_i && !iec_wr_i) |=> ((ie_o & $past(wbits_i)) == $past(wbits_i)));

endmodule

// File: rtl/ecc_regfront.sv
`timescale 1ns/1ps
module ecc_regfront
  import ecc_regfront_pkg::*;
#(
  parameter int ADDR_W     = 9,
  parameter int PAR_WORDS  = 28,
  parameter int EREP_WORDS = 64,
  parameter int DONE_DLY   = 4,
  localparam int PIDX_W    = (PAR_WORDS  > 1) ? $clog2(PAR_WORDS)  : 1,
  localparam int EIDX_W    = (EREP_WORDS > 1) ? $clog2(EREP_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              par_we,
  input  logic [PIDX_W-1:0] par_idx,
  input  logic [31:0]       par_wdata,
  input  logic              erep_we,
  input  logic [EIDX_W-1:0] erep_idx,
  input  logic [31:0]       erep_wdata,
  input  logic              res_ld,
  input  logic              res_err,
  input  logic              res_uncor,
  input  logic [6:0]        res_total,
  input  logic [6:0]        res_entries,
  output logic              irq
);

  localparam logic [ADDR_W-1:0] A_CTRL    = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_CNT     = ADDR_W'(OFS_CNT);
  localparam logic [ADDR_W-1:0] A_DATA    = ADDR_W'(OFS_DATA);
  localparam logic [ADDR_W-1:0] A_CCLR    = ADDR_W'(OFS_CCLR);
  localparam logic [ADDR_W-1:0] A_PAR_LO  = ADDR_W'(OFS_PAR);
  localparam logic [ADDR_W-1:0] A_PAR_HI  = ADDR_W'(OFS_PAR + 4*PAR_WORDS);
  localparam logic [ADDR_W-1:0] A_EREP_LO = ADDR_W'(OFS_EREP);
  localparam logic [ADDR_W-1:0] A_EREP_HI = ADDR_W'(OFS_EREP + 4*EREP_WORDS);
  localparam logic [ADDR_W-1:0] A_STAT    = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_IES     = ADDR_W'(OFS_IES);
  localparam logic [ADDR_W-1:0] A_IEC     = ADDR_W'(OFS_IEC);
  localparam logic [ADDR_W-1:0] A_IEV     = ADDR_W'(OFS_IEV);

  // Reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ni = rsync_q[1];

  // Decode
  logic        wr, wr_ctrl, wr_cnt, wr_data, wr_cclr, wr_stat, wr_ies, wr_iec;
  logic        in_par, in_erep;
  logic [31:0] msk, wdm;
  logic [PIDX_W-1:0] par_ridx;
  logic [EIDX_W-1:0] erep_ridx;

  always_comb begin
    wr      = bus_sel && bus_wr;
    wr_ctrl = wr && (bus_addr == A_CTRL);
    wr_cnt  = wr && (bus_addr == A_CNT);
    wr_data = wr && (bus_addr == A_DATA);
    wr_cclr = wr && (bus_addr == A_CCLR);
    wr_stat = wr && (bus_addr == A_STAT);
    wr_ies  = wr && (bus_addr == A_IES);
    wr_iec  = wr && (bus_addr == A_IEC);
    msk     = lane_mask(bus_be);
    wdm     = bus_wdata & msk;
    in_par  = (bus_addr[1:0] == 2'b00) && (bus_addr >= A_PAR_LO)  && (bus_addr < A_PAR_HI);
    in_erep = (bus_addr[1:0] == 2'b00) && (bus_addr >= A_EREP_LO) && (bus_addr < A_EREP_HI);
    par_ridx  = PIDX_W'((bus_addr - A_PAR_LO) >> 2);
    erep_ridx = EIDX_W'((bus_addr - A_EREP_LO) >> 2);
  end

  // Control and count registers
  logic [31:0] ctrl_q, ctrl_d, cnt_q, cnt_d;
  logic        ctrl_ce;

  always_comb begin
    ctrl_d = ctrl_q;
    ctrl_d[CB_INIT] = 1'b0;
    if (wr_ctrl) ctrl_d = ((ctrl_d & ~msk) | wdm) & CTRL_KEEP;
    if (wr_cclr) ctrl_d = ctrl_d & ~wdm;
    ctrl_ce = wr_ctrl | wr_cclr | ctrl_q[CB_INIT];
    cnt_d   = ((cnt_q & ~msk) | wdm) & CNT_KEEP;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (ctrl_ce) ctrl_q <= ctrl_d;
      if (wr_cnt)  cnt_q  <= cnt_d;
    end
  end

  logic       init, push, enc_done, dec_done;
  logic [2:0] lanes;
  assign init  = ctrl_q[CB_INIT];
  assign push  = wr_data && ctrl_q[CB_EN] && !init;
  assign lanes = 3'($countones(bus_be));

  ecc_feed_counter #(
    .DONE_DLY (DONE_DLY),
    .BLK_W    (11),
    .PAR_W    (7)
  ) u_feed (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .init_i     (init),
    .enc_i      (ctrl_q[CB_ENC]),
    .push_i     (push),
    .lanes_i    (lanes),
    .blk_i      (cnt_q[10:0]),
    .par_i      (cnt_q[22:16]),
    .enc_done_o (enc_done),
    .dec_done_o (dec_done)
  );

  logic [31:0] par_rdata, erep_rdata;

  ecc_result_store #(
    .PAR_WORDS  (PAR_WORDS),
    .EREP_WORDS (EREP_WORDS),
    .PIDX_W     (PIDX_W),
    .EIDX_W     (EIDX_W)
  ) u_store (
    .clk          (clk),
    .rst_ni       (rst_ni),
    .init_i       (init),
    .par_we_i     (par_we),
    .par_widx_i   (par_idx),
    .par_wdata_i  (par_wdata),
    .par_ridx_i   (par_ridx),
    .par_rdata_o  (par_rdata),
    .erep_we_i    (erep_we),
    .erep_widx_i  (erep_idx),
    .erep_wdata_i (erep_wdata),
    .erep_ridx_i  (erep_ridx),
    .erep_rdata_o (erep_rdata)
  );

  ecc_res_t    res;
  logic [31:0] stat;
  logic [3:0]  ie;
  assign res = '{err: res_err, uncor: res_uncor, total: res_total, entries: res_entries};

  ecc_irq_ctrl u_irq (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .stat_wr_i  (wr_stat),
    .ies_wr_i   (wr_ies),
    .iec_wr_i   (wr_iec),
    .wbits_i    (wdm[3:0]),
    .enc_done_i (enc_done),
    .dec_done_i (dec_done),
    .res_ld_i   (res_ld),
    .res_i      (res),
    .stat_o     (stat),
    .ie_o       (ie),
    .irq_o      (irq)
  );

  // Read mux
  always_comb begin
    bus_rdata = 32'h0;
    if (bus_addr == A_CTRL)      bus_rdata = ctrl_q;
    else if (bus_addr == A_CNT)  bus_rdata = cnt_q;
    else if (in_par)             bus_rdata = par_rdata;
    else if (in_erep)            bus_rdata = erep_rdata;
    else if (bus_addr == A_STAT) bus_rdata = stat;
    else if (bus_addr == A_IEV)  bus_rdata = {28'h0, ie};
  end

  // R3
  init_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (ctrl_q[CB_INIT] && !wr_ctrl) |=> !ctrl_q[CB_INIT]);

  // R2
  ctrl_clear_en_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_cclr && wdm[CB_EN]) |=> !ctrl_q[CB_EN]);

endmodule

// File: tb/tb_ecc_regfront.sv
`timescale 1ns/1ps
module tb_ecc_regfront;

  localparam int DLY   = 4;
  localparam int PARW  = 28;
  localparam int EREPW = 64;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [8:0]  bus_addr;
  logic [3:0]  bus_be;
  logic [31:0] bus_wdata, bus_rdata;
  logic        par_we, erep_we, res_ld, res_err, res_uncor;
  logic [4:0]  par_idx;
  logic [5:0]  erep_idx;
  logic [31:0] par_wdata, erep_wdata;
  logic [6:0]  res_total, res_entries;
  logic        irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done_flag = 1'b0;

  always #2.5 clk = ~clk;

  ecc_regfront #(
    .ADDR_W(9), .PAR_WORDS(PARW), .EREP_WORDS(EREPW), .DONE_DLY(DLY)
  ) dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .par_we(par_we), .par_idx(par_idx),
    .par_wdata(par_wdata), .erep_we(erep_we), .erep_idx(erep_idx),
    .erep_wdata(erep_wdata), .res_ld(res_ld), .res_err(res_err),
    .res_uncor(res_uncor), .res_total(res_total), .res_entries(res_entries),
    .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_be = 4'h0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    bus_addr = a; bus_sel = 1'b1; bus_wr = 1'b0;
    #1;
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [8:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic par_load(input logic [4:0] i, input logic [31:0] d);
    @(negedge clk); par_we = 1'b1; par_idx = i; par_wdata = d;
    @(negedge clk); par_we = 1'b0;
  endtask

  task automatic erep_load(input logic [5:0] i, input logic [31:0] d);
    @(negedge clk); erep_we = 1'b1; erep_idx = i; erep_wdata = d;
    @(negedge clk); erep_we = 1'b0;
  endtask

  task automatic res_load(input logic e, input logic u, input logic [6:0] t, input logic [6:0] n);
    @(negedge clk); res_ld = 1'b1; res_err = e; res_uncor = u; res_total = t; res_entries = n;
    @(negedge clk); res_ld = 1'b0;
  endtask

  function automatic logic [3:0] one_lane(input int k);
    return 4'b0001 << (k % 4);
  endfunction

  function automatic int target_of(input int blk, input int par, input bit enc);
    return enc ? blk : blk + par;
  endfunction

  // Completion: not set one cycle early, set exactly DLY cycles after the last push edge
  task automatic await_done(input string req, input logic [31:0] exp_bits);
    logic [31:0] d;
    repeat (DLY - 1) @(posedge clk);
    @(negedge clk);
    rd(9'h184, d);
    check(req, d & 32'hC, 32'h0);
    @(posedge clk);
    @(negedge clk);
    rd(9'h184, d);
    check(req, d & 32'hC, exp_bits);
  endtask

  task automatic stream(input int total);
    int rem = total;
    while (rem > 0) begin
      if (rem >= 4 && ($urandom % 4) != 0) begin
        wr(9'h008, $urandom, 4'hF);
        rem -= 4;
      end else begin
        wr(9'h008, $urandom, one_lane($urandom % 4));
        rem -= 1;
      end
    end
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done_flag) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5EED_0042));
    bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_be = 0; bus_wdata = 0;
    par_we = 0; par_idx = 0; par_wdata = 0; erep_we = 0; erep_idx = 0; erep_wdata = 0;
    res_ld = 0; res_err = 0; res_uncor = 0; res_total = 0; res_entries = 0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd_chk("R1 ctrl", 9'h000, 32'h0);
    rd_chk("R1 count", 9'h004, 32'h0);
    rd_chk("R1 status", 9'h184, 32'h0);
    rd_chk("R1 ie", 9'h190, 32'h0);
    rd_chk("R1 parity", 9'h014, 32'h0);
    check("R1 irq", {31'h0, irq}, 32'h0);

    // R4 count register fields
    wr(9'h004, 32'hFFFF_FFFF, 4'hF);
    rd_chk("R4 count mask", 9'h004, 32'h007F_07FF);
    wr(9'h004, 32'h0000_0000, 4'b0100);
    rd_chk("R4 lane write", 9'h004, 32'h0000_07FF);

    // R2 / R3 control load, init pulse, clear address, byte lanes
    wr(9'h000, 32'hFFFF_FFFF, 4'hF);
    rd_chk("R3 init visible", 9'h000, 32'h0000_07F7);
    @(negedge clk);
    rd_chk("R3 init self-clears", 9'h000, 32'h0000_07F5);
    wr(9'h00C, 32'h0000_0001, 4'hF);
    rd_chk("R2 clear enable", 9'h000, 32'h0000_07F4);
    wr(9'h000, 32'h0000_0000, 4'b0010);
    rd_chk("R2 lane1 load", 9'h000, 32'h0000_00F4);
    wr(9'h00C, 32'hFFFF_FFFF, 4'hF);
    rd_chk("R2 clear all", 9'h000, 32'h0);

    // R12 unmapped and unaligned
    rd_chk("R12 gap", 9'h010, 32'h0);
    rd_chk("R12 top", 9'h1FC, 32'h0);
    rd_chk("R12 unaligned", 9'h005, 32'h0);

    // R10 result windows
    par_load(5'd0, 32'hA5A5_0001);
    par_load(5'(PARW-1), 32'h5A5A_001B);
    erep_load(6'd0, 32'h00FF_0010);
    erep_load(6'(EREPW-1), 32'h1234_0003);
    rd_chk("R10 parity first", 9'h014, 32'hA5A5_0001);
    rd_chk("R10 parity last", 9'(32'h14 + 4*(PARW-1)), 32'h5A5A_001B);
    rd_chk("R10 erep first", 9'h084, 32'h00FF_0010);
    rd_chk("R10 erep last", 9'(32'h84 + 4*(EREPW-1)), 32'h1234_0003);
    wr(9'h014, 32'hFFFF_FFFF, 4'hF);
    rd_chk("R10 bus write ignored", 9'h014, 32'hA5A5_0001);

    // R3 init clears results
    wr(9'h000, 32'h0000_0002, 4'hF);
    @(negedge clk);
    rd_chk("R3 parity cleared", 9'h014, 32'h0);
    rd_chk("R3 erep cleared", 9'(32'h84 + 4*(EREPW-1)), 32'h0);

    // R9 verdict load, R8 per-bit acknowledge
    res_load(1'b1, 1'b0, 7'd5, 7'd3);
    rd_chk("R9 verdict", 9'h184, 32'h0305_0001);
    res_load(1'b0, 1'b1, 7'd9, 7'd2);
    rd_chk("R9 verdict accumulate", 9'h184, 32'h0209_0003);
    wr(9'h184, 32'h0000_0002, 4'hF);
    rd_chk("R8 ack uncor only", 9'h184, 32'h0209_0001);
    wr(9'h184, 32'h0000_0001, 4'hF);
    rd_chk("R8 ack err clears fields", 9'h184, 32'h0);

    // R6 directed encode: 10 bytes = word, word, lane0, lane3
    wr(9'h004, 32'h0000_000A, 4'hF);
    wr(9'h000, 32'h0000_0037, 4'hF);
    wr(9'h008, 32'h1111_1111, 4'hF);
    wr(9'h008, 32'h2222_2222, 4'hF);
    wr(9'h008, 32'h0000_0033, 4'b0001);
    wr(9'h008, 32'h4400_0000, 4'b1000);
    await_done("R6 encode done", 32'h4);

    // R11 interrupt enables
    wr(9'h188, 32'h0000_0004, 4'hF);
    rd_chk("R11 ie set", 9'h190, 32'h4);
    check("R11 irq on", {31'h0, irq}, 32'h1);
    wr(9'h188, 32'h0000_0008, 4'hF);
    wr(9'h18C, 32'h0000_0004, 4'hF);
    rd_chk("R11 ie clear", 9'h190, 32'h8);
    check("R11 irq masked", {31'h0, irq}, 32'h0);

    // R8 acknowledge one bit leaves the other
    wr(9'h184, 32'h0000_0001, 4'hF);
    rd_chk("R8 encf kept", 9'h184, 32'h4);
    wr(9'h184, 32'h0000_0004, 4'hF);
    rd_chk("R8 encf acked", 9'h184, 32'h0);

    // R7 directed decode: 6 + 3 = 9 bytes
    wr(9'h004, 32'h0003_0006, 4'hF);
    wr(9'h000, 32'h0000_0003, 4'hF);
    wr(9'h008, 32'h0, 4'hF);
    wr(9'h008, 32'h0, 4'hF);
    wr(9'h008, 32'h0, 4'b0100);
    await_done("R7 decode done", 32'h8);
    check("R11 irq decode", {31'h0, irq}, 32'h1);
    wr(9'h184, 32'h0000_000F, 4'hF);
    check("R11 irq after ack", {31'h0, irq}, 32'h0);

    // R5 pushes while disabled are not counted
    wr(9'h004, 32'h0000_0008, 4'hF);
    wr(9'h000, 32'h0000_0006, 4'hF);
    wr(9'h008, 32'h0, 4'hF);
    wr(9'h008, 32'h0, 4'hF);
    wr(9'h000, 32'h0000_0005, 4'hF);
    wr(9'h008, 32'h0, 4'hF);
    repeat (DLY + 3) @(negedge clk);
    rd_chk("R5 disabled pushes ignored", 9'h184, 32'h0);
    wr(9'h008, 32'h0, 4'hF);
    await_done("R5 enabled pushes counted", 32'h4);
    wr(9'h008, 32'h0, 4'hF);
    repeat (DLY + 3) @(negedge clk);
    wr(9'h184, 32'h0000_000F, 4'hF);
    repeat (DLY + 3) @(negedge clk);
    rd_chk("R5 pushes after target ignored", 9'h184, 32'h0);

    // Random blocks, both modes, random word/byte mixes (R6, R7, R10)
    for (int it = 0; it < 40; it++) begin
      int blk = 1 + ($urandom % 40);
      int par = $urandom % 16;
      bit enc = $urandom % 2;
      int pi  = $urandom % PARW;
      logic [31:0] pv = $urandom;
      wr(9'h004, {9'h0, 7'(par), 5'h0, 11'(blk)}, 4'hF);
      wr(9'h000, {21'h0, 7'($urandom), 1'b0, enc, 2'b11}, 4'hF);
      stream(target_of(blk, par, enc));
      await_done(enc ? "R6 random encode" : "R7 random decode", enc ? 32'h4 : 32'h8);
      wr(9'h184, 32'h0000_000F, 4'hF);
      par_load(5'(pi), pv);
      rd_chk("R10 random parity", 9'(32'h14 + 4*pi), pv);
    end

    done_flag = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule